// File: doc/BRIEF.md
# Keyboard Controller Command Engine

This block is the host-side command and register engine of a PS/2-style keyboard controller. The host reaches it through a byte-wide write port with one select line. The select line picks either the command address or the data address. A write to the command address runs a controller command at once. A write to the data address either supplies the second byte of a two-byte command or is passed on to the keyboard.

The engine holds the controller mode byte, the status bits it owns, and an output-port register. The output port drives the A20 gate line and can raise a system-reset request. Any byte the controller must send back goes to the output-buffer arbiter as a one-cycle response, tagged for the keyboard channel or the aux channel. Bytes meant for the keyboard or the mouse leave on two forward strobes. Every effect shows on the registered outputs on the clock edge that accepts the write.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset the mode byte reads 0x03, the owned status bits read 0x18 and the output port reads 0xCF. No response, forward or reset-request strobe is active.
- R2: The read commands respond once on the keyboard channel (resp_aux = 0), one cycle after the write. Command 0x20 returns the mode byte, 0xD0 returns the output port, 0xC0 returns 0x80, and 0xA9 and 0xAB each return 0x00.
- R3: Command 0xAA sets status bit 2 and responds with 0x55 on the keyboard channel.
- R4: Command 0xA7 sets mode bit 5 and 0xA8 clears it. Command 0xAD sets mode bit 4 and 0xAE clears it.
- R5: Command 0xDF sets output-port bit 1 and 0xDD clears it. a20_gate always equals output-port bit 1.
- R6: A command in the range 0xF0 to 0xFF with bit 0 clear gives a one-cycle sys_reset_req pulse. With bit 0 set it changes nothing.
- R7: After command 0x60, the next data write loads the mode byte. xlate_en follows mode bit 6.
- R8: After command 0xD1, the next data write loads the output port. When that byte has bit 0 clear, sys_reset_req pulses for one cycle.
- R9: After command 0xD2 or 0xD3, the next data byte comes back as a response: on the keyboard channel for 0xD2 and on the aux channel (resp_aux = 1) for 0xD3.
- R10: After command 0xD4, the next data byte leaves on the aux forward strobe and mode bit 5 is cleared.
- R11: A data write with no pending command goes out on the keyboard forward strobe and clears mode bit 4. Every data write clears the pending command.
- R12: An unrecognised command code changes no register and gives no strobe.
- R13: A pending command survives commands that take no second byte. A later two-byte command replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_cmd_sel | input | 1 | 1 selects the command address, 0 the data address |
| host_wdata | input | 8 | Host write byte |
| resp_valid | output | 1 | Response byte offered to the output-buffer arbiter |
| resp_aux | output | 1 | Response belongs to the aux channel |
| resp_data | output | 8 | Response byte |
| kbd_tx_valid | output | 1 | Byte forwarded to the keyboard |
| kbd_tx_data | output | 8 | Keyboard forward byte |
| aux_tx_valid | output | 1 | Byte forwarded to the mouse |
| aux_tx_data | output | 8 | Mouse forward byte |
| ctrl_mode | output | 8 | Mode byte |
| ctrl_status | output | 8 | Status bits owned by this block |
| outport | output | 8 | Output-port register |
| a20_gate | output | 1 | A20 gate line |
| xlate_en | output | 1 | Scan-code translation enable |
| sys_reset_req | output | 1 | One-cycle system-reset request |

## Verification
Every result of a write is due on the first rising edge after the write is presented: register updates, response and forward strobes, and the reset pulse. Nothing is pipelined deeper than that. The bench drives each write on a falling edge and steps its behavioural model once for that write. It then waits through one rising edge and compares every output on the following falling edge, so each comparison sees exactly one cycle of latency. Strobes are also checked to be low on idle cycles. This catches pulses that last too long or arrive late.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // bit positions that other logic decodes
  localparam int MODE_KBD_OFF = 4;
  localparam int MODE_AUX_OFF = 5;
  localparam int MODE_XLATE   = 6;
  localparam int OUTP_RUN     = 0;
  localparam int OUTP_A20     = 1;
  localparam int STAT_PASS    = 2;

  // command codes
  localparam byte_t C_RD_MODE  = 8'h20;
  localparam byte_t C_WR_MODE  = 8'h60;
  localparam byte_t C_AUX_OFF  = 8'hA7;
  localparam byte_t C_AUX_ON   = 8'hA8;
  localparam byte_t C_AUX_TEST = 8'hA9;
  localparam byte_t C_SELFTEST = 8'hAA;
  localparam byte_t C_KBD_TEST = 8'hAB;
  localparam byte_t C_KBD_OFF  = 8'hAD;
  localparam byte_t C_KBD_ON   = 8'hAE;
  localparam byte_t C_RD_IN    = 8'hC0;
  localparam byte_t C_RD_OUTP  = 8'hD0;
  localparam byte_t C_WR_OUTP  = 8'hD1;
  localparam byte_t C_FAKE_KBD = 8'hD2;
  localparam byte_t C_FAKE_AUX = 8'hD3;
  localparam byte_t C_TO_MOUSE = 8'hD4;
  localparam byte_t C_A20_OFF  = 8'hDD;
  localparam byte_t C_A20_ON   = 8'hDF;

  typedef enum logic [2:0] {
    TGT_FWD_KBD, TGT_MODE, TGT_OUTP, TGT_FAKE_KBD, TGT_FAKE_AUX, TGT_MOUSE
  } tgt_e;

  typedef enum logic [1:0] {RS_MODE, RS_OUTP, RS_CONST} rsel_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  byte_t cmd,
  output logic  resp_en,
  output rsel_e resp_sel,
  output byte_t resp_const,
  output logic  latch_en,
  output tgt_e  latch_tgt,
  output logic  selftest,
  output byte_t mode_set,
  output byte_t mode_clr,
  output logic  a20_on,
  output logic  a20_off,
  output logic  pulse_rst
);
  localparam byte_t PASS_CODE = 8'h55;
  localparam byte_t INPORT    = 8'h80;

  always_comb begin
    resp_en    = 1'b0;
    resp_sel   = RS_CONST;
    resp_const = '0;
    latch_en   = 1'b0;
    latch_tgt  = TGT_FWD_KBD;
    selftest   = 1'b0;
    mode_set   = '0;
    mode_clr   = '0;
    a20_on     = 1'b0;
    a20_off    = 1'b0;
    pulse_rst  = 1'b0;
    if (cmd[BYTE_W-1 -: 4] == 4'hF) begin
      pulse_rst = ~cmd[0];
    end else begin
      case (cmd)
        C_RD_MODE:  begin resp_en = 1'b1; resp_sel = RS_MODE; end
        C_RD_OUTP:  begin resp_en = 1'b1; resp_sel = RS_OUTP; end
        C_RD_IN:    begin resp_en = 1'b1; resp_const = INPORT; end
        C_AUX_TEST,
        C_KBD_TEST: resp_en = 1'b1;
        C_SELFTEST: begin resp_en = 1'b1; resp_const = PASS_CODE; selftest = 1'b1; end
        C_WR_MODE:  begin latch_en = 1'b1; latch_tgt = TGT_MODE; end
        C_WR_OUTP:  begin latch_en = 1'b1; latch_tgt = TGT_OUTP; end
        C_FAKE_KBD: begin latch_en = 1'b1; latch_tgt = TGT_FAKE_KBD; end
        C_FAKE_AUX: begin latch_en = 1'b1; latch_tgt = TGT_FAKE_AUX; end
        C_TO_MOUSE: begin latch_en = 1'b1; latch_tgt = TGT_MOUSE; end
        C_AUX_OFF:  mode_set[MODE_AUX_OFF] = 1'b1;
        C_AUX_ON:   mode_clr[MODE_AUX_OFF] = 1'b1;
        C_KBD_OFF:  mode_set[MODE_KBD_OFF] = 1'b1;
        C_KBD_ON:   mode_clr[MODE_KBD_OFF] = 1'b1;
        C_A20_ON:   a20_on  = 1'b1;
        C_A20_OFF:  a20_off = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_pend_latch.sv
module kbc_pend_latch
  import kbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  tgt_e load_tgt,
  input  logic consume,
  output tgt_e tgt
);
  always_ff @(posedge clk) begin
    if (rst)          tgt <= TGT_FWD_KBD;
    else if (load)    tgt <= load_tgt;
    else if (consume) tgt <= TGT_FWD_KBD;
  end
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t STAT_INIT = 8'h18,
  parameter byte_t OUTP_INIT = 8'hCF
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cmd_stb,
  input  byte_t mode_set,
  input  byte_t mode_clr,
  input  logic  selftest,
  input  logic  a20_on,
  input  logic  a20_off,
  input  logic  pulse_rst,
  input  logic  data_stb,
  input  tgt_e  tgt,
  input  byte_t wdata,
  output byte_t mode_q,
  output byte_t stat_q,
  output byte_t outp_q,
  output logic  rst_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_INIT;
      stat_q  <= STAT_INIT;
      outp_q  <= OUTP_INIT;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (cmd_stb) begin
        mode_q <= (mode_q | mode_set) & ~mode_clr;
        if (selftest) stat_q[STAT_PASS] <= 1'b1;
        if (a20_on)   outp_q[OUTP_A20]  <= 1'b1;
        if (a20_off)  outp_q[OUTP_A20]  <= 1'b0;
        if (pulse_rst) rst_req <= 1'b1;
      end else if (data_stb) begin
        case (tgt)
          TGT_FWD_KBD: mode_q[MODE_KBD_OFF] <= 1'b0;
          TGT_MOUSE:   mode_q[MODE_AUX_OFF] <= 1'b0;
          TGT_MODE:    mode_q <= wdata;
          TGT_OUTP: begin
            outp_q  <= wdata;
            rst_req <= ~wdata[OUTP_RUN];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter byte_t MODE_INIT = 8'h03,
  parameter byte_t STAT_INIT = 8'h18,
  parameter byte_t OUTP_INIT = 8'hCF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_cmd_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              resp_valid,
  output logic              resp_aux,
  output logic [BYTE_W-1:0] resp_data,
  output logic              kbd_tx_valid,
  output logic [BYTE_W-1:0] kbd_tx_data,
  output logic              aux_tx_valid,
  output logic [BYTE_W-1:0] aux_tx_data,
  output logic [BYTE_W-1:0] ctrl_mode,
  output logic [BYTE_W-1:0] ctrl_status,
  output logic [BYTE_W-1:0] outport,
  output logic              a20_gate,
  output logic              xlate_en,
  output logic              sys_reset_req
);
  logic  cmd_stb, data_stb;
  logic  d_resp_en, d_latch_en, d_selftest, d_a20_on, d_a20_off, d_pulse;
  rsel_e d_resp_sel;
  byte_t d_resp_const, d_mode_set, d_mode_clr;
  tgt_e  d_latch_tgt, pend_tgt;
  byte_t mode_q, stat_q, outp_q, resp_pick;

  assign cmd_stb  = host_wr &  host_cmd_sel;
  assign data_stb = host_wr & ~host_cmd_sel;

  kbc_cmd_decode u_dec (
    .cmd(host_wdata), .resp_en(d_resp_en), .resp_sel(d_resp_sel),
    .resp_const(d_resp_const), .latch_en(d_latch_en), .latch_tgt(d_latch_tgt),
    .selftest(d_selftest), .mode_set(d_mode_set), .mode_clr(d_mode_clr),
    .a20_on(d_a20_on), .a20_off(d_a20_off), .pulse_rst(d_pulse)
  );

  kbc_pend_latch u_pend (
    .clk(clk), .rst(rst), .load(cmd_stb & d_latch_en), .load_tgt(d_latch_tgt),
    .consume(data_stb), .tgt(pend_tgt)
  );

  kbc_ctrl_regs #(
    .MODE_INIT(MODE_INIT), .STAT_INIT(STAT_INIT), .OUTP_INIT(OUTP_INIT)
  ) u_regs (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .mode_set(d_mode_set),
    .mode_clr(d_mode_clr), .selftest(d_selftest), .a20_on(d_a20_on),
    .a20_off(d_a20_off), .pulse_rst(d_pulse), .data_stb(data_stb),
    .tgt(pend_tgt), .wdata(host_wdata), .mode_q(mode_q), .stat_q(stat_q),
    .outp_q(outp_q), .rst_req(sys_reset_req)
  );

  always_comb begin
    case (d_resp_sel)
      RS_MODE: resp_pick = mode_q;
      RS_OUTP: resp_pick = outp_q;
      default: resp_pick = d_resp_const;
    endcase
  end

  // response and forward strobes, one cycle after the host write
  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid   <= 1'b0;
      resp_aux     <= 1'b0;
      resp_data    <= '0;
      kbd_tx_valid <= 1'b0;
      kbd_tx_data  <= '0;
      aux_tx_valid <= 1'b0;
      aux_tx_data  <= '0;
    end else begin
      resp_valid   <= 1'b0;
      kbd_tx_valid <= 1'b0;
      aux_tx_valid <= 1'b0;
      if (cmd_stb && d_resp_en) begin
        resp_valid <= 1'b1;
        resp_aux   <= 1'b0;
        resp_data  <= resp_pick;
      end else if (data_stb) begin
        case (pend_tgt)
          TGT_FAKE_KBD, TGT_FAKE_AUX: begin
            resp_valid <= 1'b1;
            resp_aux   <= (pend_tgt == TGT_FAKE_AUX);
            resp_data  <= host_wdata;
          end
          TGT_FWD_KBD: begin
            kbd_tx_valid <= 1'b1;
            kbd_tx_data  <= host_wdata;
          end
          TGT_MOUSE: begin
            aux_tx_valid <= 1'b1;
            aux_tx_data  <= host_wdata;
          end
          default: ;
        endcase
      end
    end
  end

  assign ctrl_mode   = mode_q;
  assign ctrl_status = stat_q;
  assign outport     = outp_q;
  assign a20_gate    = outp_q[OUTP_A20];
  assign xlate_en    = mode_q[MODE_XLATE];
endmodule

// File: rtl/kbc_cmd_engine_chk.sv
module kbc_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       host_wr,
  input logic       host_cmd_sel,
  input logic [7:0] host_wdata,
  input logic       resp_valid,
  input logic [7:0] resp_data,
  input logic       kbd_tx_valid,
  input logic       aux_tx_valid,
  input logic [7:0] ctrl_mode,
  input logic [7:0] ctrl_status,
  input logic [7:0] outport,
  input logic       a20_gate,
  input logic       sys_reset_req
);
  // R1
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_mode == 8'h03 && ctrl_status == 8'h18 &&
                    outport == 8'hCF && !resp_valid && !sys_reset_req));
  // R2
  a_r2_resp_follows_write: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(host_wr));
  // R3
  a_r3_selftest: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_cmd_sel && host_wdata == 8'hAA) |=>
      (resp_valid && resp_data == 8'h55 && ctrl_status[2]));
  // R5
  a_r5_a20_on: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_cmd_sel && host_wdata == 8'hDF) |=> a20_gate);
  a_r5_a20_off: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_cmd_sel && host_wdata == 8'hDD) |=> !a20_gate);
  // R6
  a_r6_reset_from_write: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |-> $past(host_wr));
  // R11
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> ($stable(ctrl_mode) && $stable(outport) &&
                  !kbd_tx_valid && !aux_tx_valid && !resp_valid));
  // R12
  a_r12_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_cmd_sel && host_wdata == 8'h00) |=>
      ($stable(ctrl_mode) && $stable(outport) && $stable(ctrl_status) &&
       !resp_valid && !sys_reset_req));
endmodule

bind kbc_cmd_engine kbc_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_cmd_sel(host_cmd_sel),
  .host_wdata(host_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
  .kbd_tx_valid(kbd_tx_valid), .aux_tx_valid(aux_tx_valid),
  .ctrl_mode(ctrl_mode), .ctrl_status(ctrl_status), .outport(outport),
  .a20_gate(a20_gate), .sys_reset_req(sys_reset_req)
);

// File: tb/sim_kbc_cmd_engine.sv
module sim_kbc_cmd_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, host_cmd_sel = 1'b0;
  logic [7:0] host_wdata = '0;
  logic resp_valid, resp_aux, kbd_tx_valid, aux_tx_valid;
  logic a20_gate, xlate_en, sys_reset_req;
  logic [7:0] resp_data, kbd_tx_data, aux_tx_data, ctrl_mode, ctrl_status, outport;

  always #2 clk = ~clk;

  kbc_cmd_engine u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_cmd_sel(host_cmd_sel),
    .host_wdata(host_wdata), .resp_valid(resp_valid), .resp_aux(resp_aux),
    .resp_data(resp_data), .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
    .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data), .ctrl_mode(ctrl_mode),
    .ctrl_status(ctrl_status), .outport(outport), .a20_gate(a20_gate),
    .xlate_en(xlate_en), .sys_reset_req(sys_reset_req)
  );

  int n_chk = 0, n_fail = 0;

  // behavioural model state
  int m_mode, m_stat, m_outp, m_pend;
  int e_rv, e_raux, e_rdata, e_kv, e_kdata, e_av, e_adata, e_rst;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit wr, input bit cs, input int d);
    e_rv = 0; e_kv = 0; e_av = 0; e_rst = 0;
    if (!wr) return;
    if (cs) begin
      if ((d & 8'hF0) == 8'hF0) e_rst = ((d & 1) == 0);
      else case (d)
        8'h20: begin e_rv = 1; e_raux = 0; e_rdata = m_mode; end
        8'hD0: begin e_rv = 1; e_raux = 0; e_rdata = m_outp; end
        8'hC0: begin e_rv = 1; e_raux = 0; e_rdata = 8'h80; end
        8'hA9, 8'hAB: begin e_rv = 1; e_raux = 0; e_rdata = 0; end
        8'hAA: begin e_rv = 1; e_raux = 0; e_rdata = 8'h55; m_stat |= 4; end
        8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: m_pend = d;
        8'hA7: m_mode |= 8'h20;
        8'hA8: m_mode &= 8'hDF;
        8'hAD: m_mode |= 8'h10;
        8'hAE: m_mode &= 8'hEF;
        8'hDF: m_outp |= 2;
        8'hDD: m_outp &= 8'hFD;
        default: ;
      endcase
    end else begin
      case (m_pend)
        0: begin e_kv = 1; e_kdata = d; m_mode &= 8'hEF; end
        8'h60: m_mode = d;
        8'hD1: begin m_outp = d; e_rst = ((d & 1) == 0); end
        8'hD2: begin e_rv = 1; e_raux = 0; e_rdata = d; end
        8'hD3: begin e_rv = 1; e_raux = 1; e_rdata = d; end
        8'hD4: begin e_av = 1; e_adata = d; m_mode &= 8'hDF; end
        default: ;
      endcase
      m_pend = 0;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "resp_valid", resp_valid, e_rv);
    if (e_rv != 0) begin
      chk(tag, "resp_aux", resp_aux, e_raux);
      chk(tag, "resp_data", resp_data, e_rdata);
    end
    chk(tag, "kbd_tx_valid", kbd_tx_valid, e_kv);
    if (e_kv != 0) chk(tag, "kbd_tx_data", kbd_tx_data, e_kdata);
    chk(tag, "aux_tx_valid", aux_tx_valid, e_av);
    if (e_av != 0) chk(tag, "aux_tx_data", aux_tx_data, e_adata);
    chk(tag, "ctrl_mode", ctrl_mode, m_mode);
    chk(tag, "ctrl_status", ctrl_status, m_stat);
    chk(tag, "outport", outport, m_outp);
    chk(tag, "a20_gate", a20_gate, (m_outp >> 1) & 1);
    chk(tag, "xlate_en", xlate_en, (m_mode >> 6) & 1);
    chk(tag, "sys_reset_req", sys_reset_req, e_rst);
  endtask

  // called on a falling edge; returns on the next falling edge after checking
  task automatic cyc(input bit wr, input bit cs, input int d, input string tag);
    host_wr = wr; host_cmd_sel = cs; host_wdata = d[7:0];
    model(wr, cs, d);
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0;
    compare(tag);
  endtask

  task automatic cmd(input int d, input string tag);
    cyc(1'b1, 1'b1, d, tag);
  endtask
  task automatic dat(input int d, input string tag);
    cyc(1'b1, 1'b0, d, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_mode = 8'h03; m_stat = 8'h18; m_outp = 8'hCF; m_pend = 0;
    e_raux = 0; e_rdata = 0; e_kdata = 0; e_adata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    e_rv = 0; e_kv = 0; e_av = 0; e_rst = 0;
    compare("R1");
    idle("R1");
    // reads and mode toggles
    cmd(8'h20, "R2");
    cmd(8'hA7, "R4"); cmd(8'h20, "R4"); cmd(8'hA8, "R4");
    cmd(8'hAD, "R4"); cmd(8'h20, "R4"); cmd(8'hAE, "R4");
    cmd(8'hAA, "R3"); idle("R3");
    cmd(8'hC0, "R2"); cmd(8'hA9, "R2"); cmd(8'hAB, "R2"); cmd(8'hD0, "R2");
    cmd(8'hDD, "R5"); cmd(8'hD0, "R5"); cmd(8'hDF, "R5"); idle("R5");
    // pulse command range
    for (int i = 0; i < 16; i++) begin
      cmd(8'hF0 + i, "R6");
      idle("R6");
    end
    // two-byte commands
    cmd(8'h60, "R7"); dat(8'h43, "R7"); cmd(8'h20, "R7");
    cmd(8'h60, "R7"); dat(8'h03, "R7");
    cmd(8'hD1, "R8"); dat(8'hCD, "R8"); cmd(8'hD0, "R8");
    cmd(8'hD1, "R8"); dat(8'hCE, "R8"); idle("R8");
    cmd(8'hD1, "R8"); dat(8'hCF, "R8");
    cmd(8'hD2, "R9"); dat(8'h5A, "R9");
    cmd(8'hD3, "R9"); dat(8'hA5, "R9");
    cmd(8'hA7, "R10"); cmd(8'hD4, "R10"); dat(8'h12, "R10"); idle("R10");
    cmd(8'hAD, "R11"); dat(8'h77, "R11"); dat(8'h78, "R11");
    cmd(8'hD2, "R11"); dat(8'h11, "R11"); dat(8'h22, "R11");
    // unrecognised codes
    cmd(8'h00, "R12"); cmd(8'h55, "R12"); cmd(8'hB0, "R12"); cmd(8'hE0, "R12");
    cmd(8'h20, "R12");
    // pending survives and is replaced
    cmd(8'hD2, "R13"); cmd(8'hA7, "R13"); cmd(8'h20, "R13"); dat(8'h33, "R13");
    cmd(8'h60, "R13"); cmd(8'hD3, "R13"); dat(8'h44, "R13");
    cmd(8'h20, "R13"); idle("R13");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule